// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block sits beside a processor core and carries out the memory traffic that brackets an interrupt handler. When the core signals that an instruction has completed and an interrupt request is pending, the sequencer takes a snapshot of the program counter, the status word and the stack pointer. It pushes the program counter and the status word to a downward-growing stack in byte-wide memory. It then reads the handler address from a two-byte vector selected by the source number and hands the core a new program counter, a new stack pointer and a status word whose interrupt-level field now holds the level of the request. The accumulator and temporary register are never stored.

On a return command the sequencer pops the same four bytes in the reverse order of the push. It hands back the saved program counter and status word unchanged, with the stack pointer restored to its value before entry. Each memory access is a single outstanding request held until acknowledged. The core loads the results on a one-cycle strobe, and a busy flag covers the whole sequence.

Top module: `irq_frame_seq`

## Requirements
- R1: After reset, busy, mem_req and ld_valid are all 0.
- R2: A sequence starts only while idle, and only on reti_cmd or on instr_done and irq_valid both high in the same cycle; irq_valid alone or instr_done alone starts nothing and issues no memory request.
- R3: Entry performs exactly four byte writes, in this order: program counter bits [7:0] at SP-1, program counter bits [15:8] at SP-2, status bits [7:0] at SP-3, status bits [15:8] at SP-4 (SP is the sp_in value at start, modulo 2^16).
- R4: After the pushes, entry performs two byte reads: first at VEC_BASE-2*irq_src (the handler high byte), then at that address +1 (the handler low byte).
- R5: Entry ends with a single-cycle ld_valid pulse, with pc_out equal to {high byte, low byte} of the vector, sp_out equal to SP-4, and ps_out equal to the saved status with bits [IL_LSB+1:IL_LSB] (bits [5:4] by default) replaced by irq_level and all other bits unchanged.
- R6: On return, four byte reads occur at SP, SP+1, SP+2, SP+3, giving status [15:8], status [7:0], program counter [15:8] and program counter [7:0]; no write occurs; ld_valid then pulses with these values on ps_out and pc_out and sp_out equal to SP+4.
- R7: When reti_cmd and an interrupt start condition arrive in the same idle cycle, the return sequence is performed.
- R8: busy is high from the cycle after a start until the ld_valid cycle, and start inputs presented while busy neither restart nor add memory operations.
- R9: mem_req, once raised, stays high with mem_addr, mem_we and mem_wdata unchanged until the cycle in which mem_ack is sampled high; only one request is outstanding.
- R10: An entry followed by a return that uses the stack pointer delivered by the entry restores the original program counter, status word and stack pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_done | input | 1 | Current instruction has completed this cycle |
| irq_valid | input | 1 | An arbitrated interrupt request is pending |
| irq_src | input | SRC_W | Source number of the pending request |
| irq_level | input | 2 | Level of the pending request |
| reti_cmd | input | 1 | Return-from-interrupt command |
| pc_in | input | ADDR_W | Current program counter |
| ps_in | input | 16 | Current status word |
| sp_in | input | ADDR_W | Current stack pointer |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 for a write, 0 for a read |
| mem_addr | output | ADDR_W | Byte address |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte, valid with mem_ack |
| mem_ack | input | 1 | Completes the request in the same cycle |
| busy | output | 1 | Sequence in progress |
| ld_valid | output | 1 | One-cycle strobe: load pc_out, ps_out, sp_out |
| pc_out | output | ADDR_W | New program counter |
| ps_out | output | 16 | New status word |
| sp_out | output | ADDR_W | New stack pointer |

## Verification
The assertions assume that mem_ack is only ever high while mem_req is high, and that mem_rdata is meaningful in that same cycle. The bench's memory model answers only an open request, after a random delay of zero to three cycles, and drops mem_ack in the following cycle, so the request is always retired on one edge. Start pulses that arrive while busy are kept to the first few cycles of a sequence, well before its shortest possible end. Random stack pointers stay clear of the vector table, so pushes never overwrite a vector.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  localparam int PS_W = 16;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PUSH = 2'd1,
    ST_VEC  = 2'd2,
    ST_POP  = 2'd3
  } seq_st_t;

  localparam logic [1:0] LAST_PUSH = 2'd3;
  localparam logic [1:0] LAST_VEC  = 2'd1;
  localparam logic [1:0] LAST_POP  = 2'd3;
endpackage

// File: rtl/irq_addr_gen.sv
module irq_addr_gen
  import irq_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int SRC_W = 3,
  parameter logic [ADDR_W-1:0] VEC_BASE = 16'hFFFC
) (
  input  seq_st_t           state,
  input  logic [1:0]        step,
  input  logic [ADDR_W-1:0] base_sp,
  input  logic [SRC_W-1:0]  src,
  input  logic [ADDR_W-1:0] sv_pc,
  input  logic [PS_W-1:0]   sv_ps,
  output logic [ADDR_W-1:0] op_addr,
  output logic              op_we,
  output logic [BYTE_W-1:0] op_wdata
);
  localparam int OFS_W = SRC_W + 1;

  logic [ADDR_W-1:0] step_ext;
  logic [ADDR_W-1:0] vec_ofs;

  assign step_ext = ADDR_W'(step);
  assign vec_ofs  = ADDR_W'({src, 1'b0});

  always_comb begin
    op_addr  = '0;
    op_we    = 1'b0;
    op_wdata = '0;
    unique case (state)
      ST_PUSH: begin
        op_we   = 1'b1;
        op_addr = base_sp - step_ext - ADDR_W'(1);
        unique case (step)
          2'd0: op_wdata = sv_pc[7:0];
          2'd1: op_wdata = sv_pc[15:8];
          2'd2: op_wdata = sv_ps[7:0];
          default: op_wdata = sv_ps[15:8];
        endcase
      end
      ST_VEC:  op_addr = VEC_BASE - vec_ofs + step_ext;
      ST_POP:  op_addr = base_sp + step_ext;
      default: op_addr = '0;
    endcase
  end

  initial begin
    assert (OFS_W < ADDR_W) else $error("vector offset wider than address");
  end
endmodule

// File: rtl/irq_mem_port.sv
module irq_mem_port
  import irq_seq_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue,
  input  logic [ADDR_W-1:0] op_addr,
  input  logic              op_we,
  input  logic [BYTE_W-1:0] op_wdata,
  input  logic              mem_ack,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [BYTE_W-1:0] mem_wdata,
  output logic              op_done
);
  assign op_done = mem_req && mem_ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else if (op_done) begin
      mem_req <= 1'b0;
    end else if (issue && !mem_req) begin
      mem_req   <= 1'b1;
      mem_we    <= op_we;
      mem_addr  <= op_addr;
      mem_wdata <= op_wdata;
    end
  end

  assert_req_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                               && $stable(mem_wdata)));

  assert_ack_in_req_R9: assert property (@(posedge clk) disable iff (rst)
    mem_ack |-> mem_req);
endmodule

// File: rtl/irq_seq_ctrl.sv
module irq_seq_ctrl
  import irq_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int SRC_W = 3,
  parameter int IL_LSB = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              instr_done,
  input  logic              irq_valid,
  input  logic [SRC_W-1:0]  irq_src,
  input  logic [1:0]        irq_level,
  input  logic              reti_cmd,
  input  logic [ADDR_W-1:0] pc_in,
  input  logic [PS_W-1:0]   ps_in,
  input  logic [ADDR_W-1:0] sp_in,
  input  logic              op_done,
  input  logic              port_req,
  input  logic [BYTE_W-1:0] rdata,
  output seq_st_t           state,
  output logic [1:0]        step,
  output logic [ADDR_W-1:0] base_sp,
  output logic [SRC_W-1:0]  src,
  output logic [ADDR_W-1:0] sv_pc,
  output logic [PS_W-1:0]   sv_ps,
  output logic              issue,
  output logic              ld_valid,
  output logic [ADDR_W-1:0] pc_out,
  output logic [PS_W-1:0]   ps_out,
  output logic [ADDR_W-1:0] sp_out
);
  localparam int FRAME_W = 4 * BYTE_W;
  localparam logic [ADDR_W-1:0] FRAME_BYTES = ADDR_W'(4);

  logic [1:0]         lvl;
  logic [FRAME_W-1:0] shreg;
  logic               take_irq;

  assign take_irq = instr_done && irq_valid;
  assign issue    = (state != ST_IDLE) && !port_req;

  function automatic logic [PS_W-1:0] with_level(input logic [PS_W-1:0] ps,
                                                 input logic [1:0] l);
    logic [PS_W-1:0] r;
    r = ps;
    r[IL_LSB +: 2] = l;
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      step     <= '0;
      base_sp  <= '0;
      src      <= '0;
      lvl      <= '0;
      sv_pc    <= '0;
      sv_ps    <= '0;
      shreg    <= '0;
      ld_valid <= 1'b0;
      pc_out   <= '0;
      ps_out   <= '0;
      sp_out   <= '0;
    end else begin
      ld_valid <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          step <= '0;
          if (reti_cmd) begin
            state   <= ST_POP;
            base_sp <= sp_in;
          end else if (take_irq) begin
            state   <= ST_PUSH;
            base_sp <= sp_in;
            sv_pc   <= pc_in;
            sv_ps   <= ps_in;
            src     <= irq_src;
            lvl     <= irq_level;
          end
        end
        ST_PUSH: begin
          if (op_done) begin
            if (step == LAST_PUSH) begin
              state <= ST_VEC;
              step  <= '0;
            end else begin
              step <= step + 2'd1;
            end
          end
        end
        ST_VEC: begin
          if (op_done) begin
            shreg <= {shreg[FRAME_W-BYTE_W-1:0], rdata};
            if (step == LAST_VEC) begin
              state    <= ST_IDLE;
              ld_valid <= 1'b1;
              pc_out   <= {shreg[BYTE_W-1:0], rdata};
              ps_out   <= with_level(sv_ps, lvl);
              sp_out   <= base_sp - FRAME_BYTES;
            end else begin
              step <= step + 2'd1;
            end
          end
        end
        ST_POP: begin
          if (op_done) begin
            shreg <= {shreg[FRAME_W-BYTE_W-1:0], rdata};
            if (step == LAST_POP) begin
              state    <= ST_IDLE;
              ld_valid <= 1'b1;
              pc_out   <= {shreg[BYTE_W-1:0], rdata};
              ps_out   <= shreg[3*BYTE_W-1:BYTE_W];
              sp_out   <= base_sp + FRAME_BYTES;
            end else begin
              step <= step + 2'd1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_no_spurious_start_R2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && !reti_cmd && !take_irq) |=> state == ST_IDLE);

  assert_reti_first_R7: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && reti_cmd) |=> state == ST_POP);

  assert_ld_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    ld_valid |=> !ld_valid);

  assert_vec_steps_R4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_VEC) |-> (step <= LAST_VEC));

  assert_pop_sp_R6: assert property (@(posedge clk) disable iff (rst)
    (ld_valid && $past(state) == ST_POP) |-> (sp_out == base_sp + FRAME_BYTES));

  assert_idle_no_req_R8: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> !port_req);
endmodule

// File: rtl/irq_frame_seq.sv
module irq_frame_seq
  import irq_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int SRC_W = 3,
  parameter int IL_LSB = 4,
  parameter logic [ADDR_W-1:0] VEC_BASE = 16'hFFFC
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              instr_done,
  input  logic              irq_valid,
  input  logic [SRC_W-1:0]  irq_src,
  input  logic [1:0]        irq_level,
  input  logic              reti_cmd,
  input  logic [ADDR_W-1:0] pc_in,
  input  logic [15:0]       ps_in,
  input  logic [ADDR_W-1:0] sp_in,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata,
  input  logic              mem_ack,
  output logic              busy,
  output logic              ld_valid,
  output logic [ADDR_W-1:0] pc_out,
  output logic [15:0]       ps_out,
  output logic [ADDR_W-1:0] sp_out
);
  seq_st_t           state;
  logic [1:0]        step;
  logic [ADDR_W-1:0] base_sp;
  logic [SRC_W-1:0]  src;
  logic [ADDR_W-1:0] sv_pc;
  logic [PS_W-1:0]   sv_ps;
  logic              issue;
  logic              op_done;
  logic [ADDR_W-1:0] op_addr;
  logic              op_we;
  logic [BYTE_W-1:0] op_wdata;

  assign busy = (state != ST_IDLE);

  irq_seq_ctrl #(.ADDR_W(ADDR_W), .SRC_W(SRC_W), .IL_LSB(IL_LSB)) u_ctrl (
    .clk(clk), .rst(rst), .instr_done(instr_done), .irq_valid(irq_valid),
    .irq_src(irq_src), .irq_level(irq_level), .reti_cmd(reti_cmd),
    .pc_in(pc_in), .ps_in(ps_in), .sp_in(sp_in), .op_done(op_done),
    .port_req(mem_req), .rdata(mem_rdata), .state(state), .step(step),
    .base_sp(base_sp), .src(src), .sv_pc(sv_pc), .sv_ps(sv_ps),
    .issue(issue), .ld_valid(ld_valid), .pc_out(pc_out), .ps_out(ps_out),
    .sp_out(sp_out)
  );

  irq_addr_gen #(.ADDR_W(ADDR_W), .SRC_W(SRC_W), .VEC_BASE(VEC_BASE)) u_agen (
    .state(state), .step(step), .base_sp(base_sp), .src(src),
    .sv_pc(sv_pc), .sv_ps(sv_ps), .op_addr(op_addr), .op_we(op_we),
    .op_wdata(op_wdata)
  );

  irq_mem_port #(.ADDR_W(ADDR_W)) u_port (
    .clk(clk), .rst(rst), .issue(issue), .op_addr(op_addr), .op_we(op_we),
    .op_wdata(op_wdata), .mem_ack(mem_ack), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .op_done(op_done)
  );

  assert_push_is_write_R3: assert property (@(posedge clk) disable iff (rst)
    (mem_req && state == ST_PUSH) |-> mem_we);

  assert_pop_is_read_R6: assert property (@(posedge clk) disable iff (rst)
    (mem_req && state == ST_POP) |-> !mem_we);
endmodule

// File: tb/tb_irq_frame_seq.sv
module tb_irq_frame_seq;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] VBASE = 16'hFFFC;
  localparam int ILB = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic instr_done = 0, irq_valid = 0, reti_cmd = 0;
  logic [2:0] irq_src = 0;
  logic [1:0] irq_level = 0;
  logic [15:0] pc_in = 0, ps_in = 0, sp_in = 0;
  logic mem_req, mem_we, mem_ack = 0;
  logic [15:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata = 0;
  logic busy, ld_valid;
  logic [15:0] pc_out, ps_out, sp_out;

  int n_chk = 0, n_fail = 0;
  bit done_flag = 0;

  logic [7:0] mem [int];
  logic [15:0] log_addr [$];
  logic        log_we [$];
  logic [7:0]  log_data [$];
  int wait_cnt = 0;
  int stab_err = 0;
  logic [15:0] open_addr;
  bit open_valid = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_frame_seq #(.ADDR_W(16), .SRC_W(3), .IL_LSB(ILB), .VEC_BASE(VBASE)) dut (
    .clk(clk), .rst(rst), .instr_done(instr_done), .irq_valid(irq_valid),
    .irq_src(irq_src), .irq_level(irq_level), .reti_cmd(reti_cmd),
    .pc_in(pc_in), .ps_in(ps_in), .sp_in(sp_in), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack), .busy(busy),
    .ld_valid(ld_valid), .pc_out(pc_out), .ps_out(ps_out), .sp_out(sp_out)
  );

  function automatic logic [7:0] rd_byte(input logic [15:0] a);
    if (mem.exists(int'(a))) return mem[int'(a)];
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  function automatic logic [15:0] exp_ps(input logic [15:0] ps, input logic [1:0] l);
    logic [15:0] r;
    r = ps;
    r[ILB +: 2] = l;
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // memory responder
  always @(negedge clk) begin
    if (mem_ack) begin
      mem_ack = 1'b0;
      open_valid = 0;
    end else if (mem_req && !rst) begin
      if (open_valid && open_addr != mem_addr) stab_err++;
      open_valid = 1;
      open_addr = mem_addr;
      if (wait_cnt == 0) begin
        mem_ack = 1'b1;
        log_addr.push_back(mem_addr);
        log_we.push_back(mem_we);
        if (mem_we) begin
          mem[int'(mem_addr)] = mem_wdata;
          log_data.push_back(mem_wdata);
        end else begin
          mem_rdata = rd_byte(mem_addr);
          log_data.push_back(mem_rdata);
        end
        wait_cnt = int'($urandom % 4);
      end else begin
        wait_cnt--;
      end
    end
  end

  task automatic clear_log();
    log_addr.delete();
    log_we.delete();
    log_data.delete();
  endtask

  task automatic noise(input int cycles);
    for (int k = 0; k < cycles; k++) begin
      @(negedge clk);
      irq_valid  = $urandom % 2;
      instr_done = $urandom % 2;
      reti_cmd   = $urandom % 2;
      chk(busy == 1'b1, "R8", "busy during sequence", busy, 1);
    end
    @(negedge clk);
    irq_valid = 0; instr_done = 0; reti_cmd = 0;
  endtask

  task automatic wait_ld(output bit got);
    got = 0;
    for (int k = 0; k < 300; k++) begin
      if (ld_valid) begin got = 1; break; end
      @(negedge clk);
    end
  endtask

  task automatic do_entry(input logic [15:0] pc, input logic [15:0] ps,
                          input logic [15:0] sp, input logic [2:0] s,
                          input logic [1:0] l, input bit with_noise,
                          output logic [15:0] new_sp);
    bit got;
    logic [15:0] va;
    logic [15:0] ea [6];
    logic [7:0]  ed [6];
    logic [15:0] epc;
    clear_log();
    @(negedge clk);
    pc_in = pc; ps_in = ps; sp_in = sp; irq_src = s; irq_level = l;
    instr_done = 1; irq_valid = 1;
    @(negedge clk);
    instr_done = 0; irq_valid = 0;
    chk(busy == 1'b1, "R8", "busy after entry start", busy, 1);
    if (with_noise) noise(4);
    wait_ld(got);
    chk(got, "R5", "entry ld_valid seen", got, 1);
    va = VBASE - {12'd0, s, 1'b0};
    epc = {rd_byte(va), rd_byte(va + 16'd1)};
    ea = '{sp - 16'd1, sp - 16'd2, sp - 16'd3, sp - 16'd4, va, va + 16'd1};
    ed = '{pc[7:0], pc[15:8], ps[7:0], ps[15:8], epc[15:8], epc[7:0]};
    chk(log_addr.size() == 6, "R3", "entry op count", log_addr.size(), 6);
    if (log_addr.size() == 6) begin
      for (int i = 0; i < 4; i++)
        chk(log_we[i] && log_addr[i] == ea[i] && log_data[i] == ed[i], "R3",
            "push byte addr/data", {log_addr[i], log_data[i]}, {ea[i], ed[i]});
      for (int i = 4; i < 6; i++)
        chk(!log_we[i] && log_addr[i] == ea[i], "R4", "vector read addr",
            log_addr[i], ea[i]);
    end
    chk(pc_out == epc, "R5", "handler pc", pc_out, epc);
    chk(ps_out == exp_ps(ps, l), "R5", "status with level", ps_out, exp_ps(ps, l));
    chk(sp_out == sp - 16'd4, "R5", "sp after entry", sp_out, sp - 16'd4);
    new_sp = sp_out;
    chk(busy == 1'b0, "R8", "idle at ld", busy, 0);
    @(negedge clk);
    chk(ld_valid == 1'b0, "R5", "ld pulse one cycle", ld_valid, 0);
  endtask

  task automatic do_return(input logic [15:0] sp, input logic [15:0] opc,
                           input logic [15:0] ops, input logic [15:0] osp,
                           input bit both, input bit with_noise);
    bit got;
    clear_log();
    @(negedge clk);
    sp_in = sp; reti_cmd = 1;
    if (both) begin instr_done = 1; irq_valid = 1; end
    @(negedge clk);
    reti_cmd = 0; instr_done = 0; irq_valid = 0;
    if (with_noise) noise(3);
    wait_ld(got);
    chk(got, "R6", "return ld_valid seen", got, 1);
    chk(log_addr.size() == 4, "R6", "return op count", log_addr.size(), 4);
    if (log_addr.size() == 4) begin
      if (both)
        chk(!log_we[0] && log_addr[0] == sp, "R7", "return wins, first op read at sp",
            {log_we[0], log_addr[0]}, {1'b0, sp});
      for (int i = 0; i < 4; i++)
        chk(!log_we[i] && log_addr[i] == sp + 16'(i), "R6", "pop read addr",
            log_addr[i], sp + 16'(i));
    end
    chk(pc_out == opc, "R10", "restored pc", pc_out, opc);
    chk(ps_out == ops, "R6", "restored status", ps_out, ops);
    chk(sp_out == osp, "R10", "restored sp", sp_out, osp);
    @(negedge clk);
    chk(ld_valid == 1'b0, "R6", "ld pulse one cycle", ld_valid, 0);
  endtask

  task automatic round(input logic [15:0] pc, input logic [15:0] ps,
                       input logic [15:0] sp, input logic [2:0] s,
                       input logic [1:0] l, input bit both, input bit nz);
    logic [15:0] nsp;
    do_entry(pc, ps, sp, s, l, nz, nsp);
    do_return(nsp, pc, ps, sp, both, nz);
  endtask

  initial begin
    int quiet_bad;
    void'($urandom(32'h1F0A_2B3C));
    repeat (3) @(negedge clk);
    rst = 0;
    chk(busy == 0 && mem_req == 0 && ld_valid == 0, "R1", "reset state",
        {busy, mem_req, ld_valid}, 0);

    // R2: partial start conditions
    quiet_bad = 0;
    clear_log();
    irq_valid = 1;
    repeat (12) begin @(negedge clk); if (busy || mem_req) quiet_bad++; end
    irq_valid = 0; instr_done = 1;
    repeat (12) begin @(negedge clk); if (busy || mem_req) quiet_bad++; end
    instr_done = 0;
    @(negedge clk);
    chk(quiet_bad == 0 && log_addr.size() == 0, "R2", "no start without both",
        quiet_bad, 0);

    // directed corners
    round(16'h1234, 16'hA5C3, 16'h0800, 3'd0, 2'd1, 0, 0);
    round(16'hBEEF, 16'h00FF, 16'h0002, 3'd7, 2'd3, 0, 0);  // stack wrap, max source
    round(16'h0001, 16'hFFCF, 16'h4000, 3'd5, 2'd0, 1, 0);  // R7 both requests
    round(16'hFFFF, 16'h0030, 16'h1000, 3'd2, 2'd2, 0, 1);  // R8 noise

    for (int i = 0; i < 30; i++) begin
      logic [15:0] rsp;
      rsp = 16'h0100 + 16'($urandom % 16'hEF00);
      round(16'($urandom), 16'($urandom), rsp, 3'($urandom), 2'($urandom),
            bit'($urandom % 4 == 0), bit'($urandom % 2));
    end

    chk(stab_err == 0, "R9", "request held stable until ack", stab_err, 0);

    if (!done_flag) begin
      done_flag = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule